// File: doc/BRIEF.md
# Indexed Register Port with Version Negotiation

This block is the control register file of a display adapter, reached through a four-word, 32-bit I/O window. Software first writes a register number to the selector word and then reads or writes the selected register through the data word. The block keeps the display mode (width, height, bits per pixel), the enable and queue-configured flags, the hardware cursor state, a fixed capability word and a small scratch array. Some values are derived at read time and are never stored: the colour depth and the line pitch in bytes.

Two writes are checked before they take effect. A write to the version register is taken only when it names one of the three known protocol versions. Software writes the configured flag after it has set up the command queue header. That write is accepted only when the header words, which a neighbouring block presents on input pins, describe an aligned and large enough region inside the queue memory. The sync register starts a drain of the command queue: the busy flag stays high until the queue parser reports that the queue is empty.

The bus front end delivers single-cycle read and write strobes. Read data appears on `rdata` one clock after the read strobe.

Top module: `gfx_regport`

## Requirements
- R1: A write at window offset 0 loads the register selector. A read at offset 0 returns the selector. Read data is registered and valid on the clock edge that samples `rd_en`.
- R2: The version register (selector 0) reads 0x90000002 after reset. A write to it is taken only for 0x90000000, 0x90000001 or 0x90000002. Any other value leaves it unchanged.
- R3: A width write (selector 2) is taken only when the value is at most MAX_WIDTH (2368). A height write (selector 3) is taken only when the value is at most MAX_HEIGHT (1770). A larger value is ignored.
- R4: A bits-per-pixel write (selector 7) is taken only for 8, 16, 24 or 32. Selector 6 reads 24 when bits per pixel is 32 and reads the bits per pixel otherwise. Selector 12 reads bits-per-pixel × width / 8.
- R5: Selector 4 reads MAX_WIDTH and selector 5 reads MAX_HEIGHT. Both are read-only.
- R6: The capability word (selector 17) has bit 0 (fill) and bit 1 (copy) set. Bits 5, 6 and 7 are set only while `hw_cursor` is high.
- R7: A non-zero write to selector 20 sets `config_ok` only if all four header words have their low two bits zero, `q_max` ≤ 0x10000 and `q_max` ≥ `q_min` + 10240. A rejected write leaves `config_ok` unchanged. A zero write clears it. Selector 20 reads `config_ok`.
- R8: A write to selector 21 sets busy. Selector 22 reads busy. Busy clears on the first edge where `queue_empty` is high and no sync write occurs.
- R9: Selectors 24, 25 and 26 (cursor id, x, y) read back what was written. On selector 27, writing 1 shows the cursor, writing 0 hides it, and any other value leaves it unchanged. Selector 27 reads the visible bit.
- R10: Selectors 1024 to 1791 read zero and ignore writes. Selectors 1792 to 1792+SCRATCH_WORDS−1 are read/write scratch words. A selector at or beyond 1792+SCRATCH_WORDS reads zero and ignores writes.
- R11: Bit 0 of a write to selector 1 drives the `enable` output. Selector 1 reads it back.
- R12: Offset 2 reads zero and ignores writes. Offset 3 reads 0xFFFFFFFF.
- R13: Reset state: selector 0, width 640, height 480, 32 bits per pixel, enable, configured, busy and cursor visibility all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 2 | Window word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| q_min | input | 32 | Queue header: first byte of command area |
| q_max | input | 32 | Queue header: end of command area |
| q_next | input | 32 | Queue header: producer position |
| q_stop | input | 32 | Queue header: consumer position |
| queue_empty | input | 1 | Queue parser reports no pending commands |
| hw_cursor | input | 1 | Display side supports a hardware cursor |
| enable | output | 1 | Adapter mode enabled |
| config_ok | output | 1 | Queue header accepted |
| cursor_visible | output | 1 | Hardware cursor shown |
| mode_width | output | 16 | Current width |
| mode_height | output | 16 | Current height |
| mode_bpp | output | 6 | Current bits per pixel |

## Verification
The assertions take two things for granted. First, the queue header pins are stable in the cycle of a write to the configured flag, so the accepted header can be checked one cycle later. Second, `addr` and `wdata` are known whenever a strobe is high. The bench changes the header words only while no strobe is active. It never raises `wr_en` and `rd_en` together, and it drives every strobe for exactly one cycle, away from the clock edge.

// File: rtl/gfx_regport.sv
module gfx_regport #(
  parameter int          MAX_WIDTH     = 2368,
  parameter int          MAX_HEIGHT    = 1770,
  parameter int          RESET_WIDTH   = 640,
  parameter int          RESET_HEIGHT  = 480,
  parameter int          RESET_BPP     = 32,
  parameter int          SCRATCH_WORDS = 16,
  parameter logic [31:0] QUEUE_BYTES   = 32'h0001_0000,
  parameter int          MIN_SPAN      = 10240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] q_min,
  input  logic [31:0] q_max,
  input  logic [31:0] q_next,
  input  logic [31:0] q_stop,
  input  logic        queue_empty,
  input  logic        hw_cursor,
  output logic        enable,
  output logic        config_ok,
  output logic        cursor_visible,
  output logic [15:0] mode_width,
  output logic [15:0] mode_height,
  output logic [5:0]  mode_bpp
);

  localparam logic [31:0] VER_BASE = 32'h9000_0000;
  localparam logic [31:0] VER_NEW  = VER_BASE | 32'd2;
  localparam int SEL_VER   = 0;
  localparam int SEL_EN    = 1;
  localparam int SEL_W     = 2;
  localparam int SEL_H     = 3;
  localparam int SEL_MAXW  = 4;
  localparam int SEL_MAXH  = 5;
  localparam int SEL_DEPTH = 6;
  localparam int SEL_BPP   = 7;
  localparam int SEL_PITCH = 12;
  localparam int SEL_CAPS  = 17;
  localparam int SEL_CFG   = 20;
  localparam int SEL_SYNC  = 21;
  localparam int SEL_BUSY  = 22;
  localparam int SEL_CID   = 24;
  localparam int SEL_CX    = 25;
  localparam int SEL_CY    = 26;
  localparam int SEL_CON   = 27;
  localparam logic [31:0] PAL_LO = 32'd1024;
  localparam logic [31:0] PAL_HI = 32'd1791;
  localparam logic [31:0] SCR_LO = 32'd1792;
  localparam logic [31:0] SCR_HI = SCR_LO + 32'(SCRATCH_WORDS);
  localparam int SCR_AW = $clog2(SCRATCH_WORDS);

  logic [31:0] index_q;
  logic [31:0] version_q;
  logic        busy_q;
  logic [31:0] cur_id_q, cur_x_q, cur_y_q;
  logic [31:0] scratch_q [SCRATCH_WORDS];

  wire val_wr   = wr_en && (addr == 2'd1);
  wire sel_wr   = wr_en && (addr == 2'd0);
  wire in_pal   = (index_q >= PAL_LO) && (index_q <= PAL_HI);
  wire in_scr   = (index_q >= SCR_LO) && (index_q < SCR_HI);
  wire [31:0] scr_off = index_q - SCR_LO;
  wire [SCR_AW-1:0] scr_sel = scr_off[SCR_AW-1:0];

  wire ver_ok = (wdata == VER_BASE) || (wdata == (VER_BASE | 32'd1)) ||
                (wdata == VER_NEW);
  wire bpp_ok = (wdata == 32'd8) || (wdata == 32'd16) ||
                (wdata == 32'd24) || (wdata == 32'd32);
  wire hdr_aligned = ((q_min | q_max | q_next | q_stop) & 32'd3) == 32'd0;
  wire hdr_ok = hdr_aligned && (q_max <= QUEUE_BYTES) &&
                ({1'b0, q_max} >= ({1'b0, q_min} + 33'(MIN_SPAN)));
  wire sync_wr = val_wr && (index_q == 32'(SEL_SYNC));

  wire [31:0] depth_rd = (mode_bpp == 6'd32) ? 32'd24 : 32'(mode_bpp);
  wire [31:0] pitch_rd = (32'(mode_bpp) * 32'(mode_width)) >> 3;
  wire [31:0] caps_rd  = 32'h3 | (hw_cursor ? 32'hE0 : 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q        <= '0;
      version_q      <= VER_NEW;
      enable         <= 1'b0;
      config_ok      <= 1'b0;
      cursor_visible <= 1'b0;
      mode_width     <= 16'(RESET_WIDTH);
      mode_height    <= 16'(RESET_HEIGHT);
      mode_bpp       <= 6'(RESET_BPP);
      cur_id_q       <= '0;
      cur_x_q        <= '0;
      cur_y_q        <= '0;
    end else begin
      if (sel_wr) index_q <= wdata;
      if (val_wr) begin
        case (index_q)
          32'(SEL_VER): if (ver_ok) version_q <= wdata;
          32'(SEL_EN):  enable <= wdata[0];
          32'(SEL_W):   if (wdata <= 32'(MAX_WIDTH)) mode_width <= wdata[15:0];
          32'(SEL_H):   if (wdata <= 32'(MAX_HEIGHT)) mode_height <= wdata[15:0];
          32'(SEL_BPP): if (bpp_ok) mode_bpp <= wdata[5:0];
          32'(SEL_CFG): begin
            if (wdata == 32'd0) config_ok <= 1'b0;
            else if (hdr_ok)    config_ok <= 1'b1;
          end
          32'(SEL_CID): cur_id_q <= wdata;
          32'(SEL_CX):  cur_x_q  <= wdata;
          32'(SEL_CY):  cur_y_q  <= wdata;
          32'(SEL_CON): begin
            if (wdata == 32'd1)      cursor_visible <= 1'b1;
            else if (wdata == 32'd0) cursor_visible <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           busy_q <= 1'b0;
    else if (sync_wr)     busy_q <= 1'b1;
    else if (queue_empty) busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SCRATCH_WORDS; i++) scratch_q[i] <= '0;
    end else if (val_wr && in_scr) begin
      scratch_q[scr_sel] <= wdata;
    end
  end

  logic [31:0] value_rd;
  always_comb begin
    value_rd = '0;
    if (in_scr) value_rd = scratch_q[scr_sel];
    else if (!in_pal) begin
      case (index_q)
        32'(SEL_VER):   value_rd = version_q;
        32'(SEL_EN):    value_rd = {31'd0, enable};
        32'(SEL_W):     value_rd = 32'(mode_width);
        32'(SEL_H):     value_rd = 32'(mode_height);
        32'(SEL_MAXW):  value_rd = 32'(MAX_WIDTH);
        32'(SEL_MAXH):  value_rd = 32'(MAX_HEIGHT);
        32'(SEL_DEPTH): value_rd = depth_rd;
        32'(SEL_BPP):   value_rd = 32'(mode_bpp);
        32'(SEL_PITCH): value_rd = pitch_rd;
        32'(SEL_CAPS):  value_rd = caps_rd;
        32'(SEL_CFG):   value_rd = {31'd0, config_ok};
        32'(SEL_BUSY):  value_rd = {31'd0, busy_q};
        32'(SEL_CID):   value_rd = cur_id_q;
        32'(SEL_CX):    value_rd = cur_x_q;
        32'(SEL_CY):    value_rd = cur_y_q;
        32'(SEL_CON):   value_rd = {31'd0, cursor_visible};
        default:        value_rd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        2'd0:    rdata <= index_q;
        2'd1:    rdata <= value_rd;
        2'd2:    rdata <= '0;
        default: rdata <= 32'hFFFF_FFFF;
      endcase
    end
  end

endmodule

module gfx_regport_chk #(
  parameter int MAX_WIDTH = 2368
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] index_q,
  input logic        busy_q,
  input logic        queue_empty,
  input logic [15:0] mode_width,
  input logic        config_ok,
  input logic [31:0] q_min,
  input logic [31:0] q_max,
  input logic [31:0] q_next,
  input logic [31:0] q_stop,
  input logic        cursor_visible
);
  wire vw = wr_en && (addr == 2'd1);

  a_r8_sync_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    vw && index_q == 32'd21 |=> busy_q);

  a_r8_busy_drains: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && queue_empty && !(vw && index_q == 32'd21) |=> !busy_q);

  a_r3_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mode_width) <= 32'(MAX_WIDTH));

  a_r3_wide_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    vw && index_q == 32'd2 && wdata > 32'(MAX_WIDTH) |=> $stable(mode_width));

  a_r7_header_checked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(config_ok) |-> $past(((q_min | q_max | q_next | q_stop) & 32'd3) == 32'd0
                               && q_max <= 32'h0001_0000));

  a_r9_show: assert property (@(posedge clk) disable iff (!rst_n)
    vw && index_q == 32'd27 && wdata == 32'd1 |=> cursor_visible);

  a_r9_hide: assert property (@(posedge clk) disable iff (!rst_n)
    vw && index_q == 32'd27 && wdata == 32'd0 |=> !cursor_visible);
endmodule

bind gfx_regport gfx_regport_chk u_chk (.*);

// File: tb/gfx_regport_bench.sv
module gfx_regport_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] q_min = '0, q_max = '0, q_next = '0, q_stop = '0;
  logic queue_empty = 1'b0, hw_cursor = 1'b0;
  logic enable, config_ok, cursor_visible;
  logic [15:0] mode_width, mode_height;
  logic [5:0] mode_bpp;

  always #10 clk = ~clk;

  gfx_regport u_gfx_regport (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input int tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic reg_rd(input logic [31:0] sel, input int tag, input logic [31:0] exp);
    logic [31:0] v;
    wr(2'd0, sel);
    rd(2'd1, v);
    chk(tag, v, exp);
  endtask

  // {read, offset, requirement, write data, expected read}
  localparam int NV = 66;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0,2'd0,4'd2,32'd0,32'd0},               // R2 version
    {1'b1,2'd1,4'd2,32'd0,32'h90000002},
    {1'b0,2'd1,4'd2,32'h90000007,32'd0},
    {1'b1,2'd1,4'd2,32'd0,32'h90000002},
    {1'b0,2'd1,4'd2,32'h90000000,32'd0},
    {1'b1,2'd1,4'd2,32'd0,32'h90000000},
    {1'b0,2'd0,4'd1,32'd2,32'd0},               // R1 selector
    {1'b1,2'd0,4'd1,32'd0,32'd2},
    {1'b1,2'd1,4'd13,32'd0,32'd640},            // R13 reset width
    {1'b0,2'd1,4'd3,32'd2368,32'd0},            // R3 bounds
    {1'b1,2'd1,4'd3,32'd0,32'd2368},
    {1'b0,2'd1,4'd3,32'd2369,32'd0},
    {1'b1,2'd1,4'd3,32'd0,32'd2368},
    {1'b0,2'd0,4'd3,32'd3,32'd0},
    {1'b0,2'd1,4'd3,32'd1771,32'd0},
    {1'b1,2'd1,4'd3,32'd0,32'd480},
    {1'b0,2'd1,4'd3,32'd1770,32'd0},
    {1'b1,2'd1,4'd3,32'd0,32'd1770},
    {1'b0,2'd0,4'd4,32'd7,32'd0},               // R4 bpp, depth, pitch
    {1'b0,2'd1,4'd4,32'd12,32'd0},
    {1'b1,2'd1,4'd4,32'd0,32'd32},
    {1'b0,2'd1,4'd4,32'd16,32'd0},
    {1'b1,2'd1,4'd4,32'd0,32'd16},
    {1'b0,2'd0,4'd4,32'd6,32'd0},
    {1'b1,2'd1,4'd4,32'd0,32'd16},
    {1'b0,2'd0,4'd4,32'd12,32'd0},
    {1'b1,2'd1,4'd4,32'd0,32'd4736},
    {1'b0,2'd0,4'd4,32'd7,32'd0},
    {1'b0,2'd1,4'd4,32'd32,32'd0},
    {1'b0,2'd0,4'd4,32'd6,32'd0},
    {1'b1,2'd1,4'd4,32'd0,32'd24},
    {1'b0,2'd0,4'd4,32'd12,32'd0},
    {1'b1,2'd1,4'd4,32'd0,32'd9472},
    {1'b0,2'd0,4'd5,32'd4,32'd0},               // R5 limits
    {1'b1,2'd1,4'd5,32'd0,32'd2368},
    {1'b0,2'd0,4'd5,32'd5,32'd0},
    {1'b1,2'd1,4'd5,32'd0,32'd1770},
    {1'b0,2'd0,4'd9,32'd24,32'd0},              // R9 cursor
    {1'b0,2'd1,4'd9,32'd5,32'd0},
    {1'b1,2'd1,4'd9,32'd0,32'd5},
    {1'b0,2'd0,4'd9,32'd27,32'd0},
    {1'b0,2'd1,4'd9,32'd1,32'd0},
    {1'b1,2'd1,4'd9,32'd0,32'd1},
    {1'b0,2'd1,4'd9,32'd3,32'd0},
    {1'b1,2'd1,4'd9,32'd0,32'd1},
    {1'b0,2'd1,4'd9,32'd0,32'd0},
    {1'b1,2'd1,4'd9,32'd0,32'd0},
    {1'b0,2'd0,4'd10,32'd1024,32'd0},           // R10 palette, scratch
    {1'b0,2'd1,4'd10,32'd77,32'd0},
    {1'b1,2'd1,4'd10,32'd0,32'd0},
    {1'b0,2'd0,4'd10,32'd1791,32'd0},
    {1'b1,2'd1,4'd10,32'd0,32'd0},
    {1'b0,2'd0,4'd10,32'd1792,32'd0},
    {1'b0,2'd1,4'd10,32'hDEADBEEF,32'd0},
    {1'b1,2'd1,4'd10,32'd0,32'hDEADBEEF},
    {1'b0,2'd0,4'd10,32'd1807,32'd0},
    {1'b0,2'd1,4'd10,32'h1234,32'd0},
    {1'b1,2'd1,4'd10,32'd0,32'h1234},
    {1'b0,2'd0,4'd10,32'd1808,32'd0},
    {1'b0,2'd1,4'd10,32'd55,32'd0},
    {1'b1,2'd1,4'd10,32'd0,32'd0},
    {1'b0,2'd0,4'd10,32'd1792,32'd0},
    {1'b1,2'd1,4'd10,32'd0,32'hDEADBEEF},
    {1'b0,2'd2,4'd12,32'd99,32'd0},             // R12 other offsets
    {1'b1,2'd2,4'd12,32'd0,32'd0},
    {1'b1,2'd3,4'd12,32'd0,32'hFFFFFFFF}
  };

  task automatic set_hdr(input logic [31:0] mn, mx, nx, st);
    @(negedge clk); q_min = mn; q_max = mx; q_next = nx; q_stop = st;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state at the ports
    chk(13, 32'(mode_width), 32'd640);
    chk(13, 32'(mode_height), 32'd480);
    chk(13, 32'(mode_bpp), 32'd32);
    chk(13, {29'd0, enable, config_ok, cursor_visible}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) begin
        rd(VEC[i][69:68], v);
        chk(int'(VEC[i][67:64]), v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][69:68], VEC[i][63:32]);
      end
    end
    chk(3, 32'(mode_height), 32'd1770);

    // R11 enable
    wr(2'd0, 32'd1); wr(2'd1, 32'd3);
    chk(11, {31'd0, enable}, 32'd1);
    reg_rd(32'd1, 11, 32'd1);
    wr(2'd0, 32'd1); wr(2'd1, 32'd2);
    chk(11, {31'd0, enable}, 32'd0);

    // R6 capabilities
    hw_cursor = 1'b0; reg_rd(32'd17, 6, 32'h3);
    hw_cursor = 1'b1; reg_rd(32'd17, 6, 32'hE3);

    // R7 header validation
    set_hdr(32'd16, 32'd10256, 32'd16, 32'd16);
    wr(2'd0, 32'd20); wr(2'd1, 32'd1);
    chk(7, {31'd0, config_ok}, 32'd1);
    reg_rd(32'd20, 7, 32'd1);
    wr(2'd1, 32'd0);
    chk(7, {31'd0, config_ok}, 32'd0);
    set_hdr(32'd16, 32'd10256, 32'd16, 32'h13);
    wr(2'd1, 32'd1);
    chk(7, {31'd0, config_ok}, 32'd0);
    set_hdr(32'd16, 32'd10252, 32'd16, 32'd16);
    wr(2'd1, 32'd1);
    chk(7, {31'd0, config_ok}, 32'd0);
    set_hdr(32'd16, 32'h10004, 32'd16, 32'd16);
    wr(2'd1, 32'd1);
    chk(7, {31'd0, config_ok}, 32'd0);
    set_hdr(32'd55296, 32'h10000, 32'd55296, 32'd55296);
    wr(2'd1, 32'd1);
    chk(7, {31'd0, config_ok}, 32'd1);
    set_hdr(32'd2, 32'h10000, 32'd16, 32'd16);
    wr(2'd1, 32'd1);
    chk(7, {31'd0, config_ok}, 32'd1);

    // R8 sync and busy
    queue_empty = 1'b0;
    wr(2'd0, 32'd21); wr(2'd1, 32'd1);
    reg_rd(32'd22, 8, 32'd1);
    @(negedge clk); queue_empty = 1'b1;
    @(negedge clk);
    reg_rd(32'd22, 8, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule